// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps track of the packets waiting in a receive buffer and shows the host one 16-bit status word for the oldest packet. The receive datapath tells it two things. It pulses a strobe for every byte written into the buffer. It sends an end-of-packet report that carries a 4-bit error code. From these, the block builds a status entry for each finished packet and holds up to `DEPTH` entries in arrival order. The block does not store the packet bytes and does not run frame checks.

The host sees the head entry on `status_word`. It reads packet bytes with `host_rd` strobes, and the block checks each strobe against the head packet's length. The host drops the head packet with a discard command. A receive-reset command returns the whole block to its empty state.

The end-of-packet report is a valid/ready stream. The datapath raises `eop_valid` with `eop_code` and holds both unchanged until a clock edge where `eop_ready` is high. That edge is the transfer. `eop_ready` is low only while the queue is full. Bytes may keep arriving while the report is stalled, and they count toward the stalled packet. Every other pin is plain control or status, with no handshake.

Top module: `rx_status_queue`

## Requirements
- R1: `status_word[15]` is 1 when no completed packet is queued. It is 0 when a completed packet sits at the head. After reset `status_word` is 16'h8000.
- R2: An incoming code is kept only if it is 4'b1000 (overrun), 4'b1011 (runt), 4'b1100 (alignment), 4'b1101 (CRC), 4'b1001 (oversize) or 4'b0010 (dribble). Every other code is stored as 4'b0000. The stored code appears in `status_word[14:11]`, so bit 14 is 1 only for the five error codes.
- R3: `status_word[10:0]` holds the packet's byte count, which is the number of `byte_in` strobes up to and including the cycle in which the end-of-packet report is taken. A packet of more than `MAX_BYTES` (1514) bytes shows a count of 1514. Its code is forced to 4'b1001, unless the stored code is already one of the five error codes.
- R4: When `DEPTH` (8) packets are queued, `status_overrun` is 1 and `eop_ready` is 0, so no report is taken. The flag clears in the cycle after a discard.
- R5: A `host_rd` strobe taken when the read offset already equals the head packet's byte count sets `rx_underrun` and `adapter_fail`. When no completed packet is queued, the in-progress byte count is used instead. Both flags stay set through discards, until a receive reset or `rst_n`.
- R6: A command with `cmd_op` = 8 removes the head entry. The next-oldest entry becomes the head, and the read offset returns to 0. The command has no effect on an empty queue.
- R7: `receiving` is 1 from the cycle after the first `byte_in` of a packet until the end-of-packet report is taken.
- R8: While no completed packet is queued, `status_word[10:0]` shows the running byte count of the packet in progress, and bits 14-11 are 0.
- R9: `rx_complete` is high for exactly one cycle, the first cycle in which a newly completed packet is at the head. This happens after a report is taken into an empty queue, and after a discard that leaves another entry at the head.
- R10: A command with `cmd_op` = 5 does all of the following in a single cycle: empties the queue, clears `rx_underrun`, `status_overrun` and `receiving`, and drops the byte count of the packet in progress.
- R11: A command with any other `cmd_op` value changes nothing at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 1 | One byte of the current packet was written to the buffer |
| eop_valid | input | 1 | End-of-packet report is valid |
| eop_ready | output | 1 | Queue can take a report |
| eop_code | input | 4 | Error code for the packet being closed |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 5 | Command opcode (5 receive reset, 8 discard head) |
| host_rd | input | 1 | Host reads one byte of the head packet |
| status_word | output | 16 | Head packet status: incomplete flag, code, byte count |
| rx_complete | output | 1 | One-cycle pulse when a completed packet becomes head |
| receiving | output | 1 | A packet is being written into the buffer |
| status_overrun | output | 1 | Queue is full |
| rx_underrun | output | 1 | Host read past the end of the head packet (sticky) |
| adapter_fail | output | 1 | Failure indication raised by an underrun |

## Verification
The bench sends a packet with each of the sixteen codes and packet lengths on both sides of the 1514-byte limit. A wrong code table or a missing count clamp would show a stray bit 14 or an overflowing byte field. It fills the queue and holds a ninth report stalled across a discard. A design that took reports while full, or that dropped the stalled report once space opened, would show a wrong head order during the drain that follows. It reads exactly to the end of a packet and then one byte more, discards, and only then resets. This catches an underrun that fires one byte early, one that clears on discard, and a receive reset that leaves an old in-progress count behind.

// File: rtl/rxsq_pkg.sv
package rxsq_pkg;
  localparam int STAT_W = 16;
  localparam int CODE_W = 4;
  localparam int CNT_W  = STAT_W - 1 - CODE_W;

  typedef logic [CODE_W-1:0] err_code_t;

  localparam err_code_t EC_NONE     = 4'b0000;
  localparam err_code_t EC_DRIBBLE  = 4'b0010;
  localparam err_code_t EC_OVERRUN  = 4'b1000;
  localparam err_code_t EC_OVERSIZE = 4'b1001;
  localparam err_code_t EC_RUNT     = 4'b1011;
  localparam err_code_t EC_ALIGN    = 4'b1100;
  localparam err_code_t EC_CRC      = 4'b1101;

  localparam logic [4:0] OP_RX_RESET = 5'd5;
  localparam logic [4:0] OP_DISCARD  = 5'd8;

  typedef struct packed {
    err_code_t        code;
    logic [CNT_W-1:0] bytes;
  } pkt_stat_t;

  // Collapse every code outside the recognised set to "no error".
  function automatic err_code_t norm_code(input err_code_t c);
    case (c)
      EC_DRIBBLE, EC_OVERRUN, EC_OVERSIZE,
      EC_RUNT, EC_ALIGN, EC_CRC: norm_code = c;
      default:                   norm_code = EC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rxsq_pkt_tracker.sv
module rxsq_pkt_tracker
  import rxsq_pkg::*;
#(
  parameter int MAX_BYTES = 1514
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             byte_in,
  input  logic             eop_take,
  input  err_code_t        eop_code,
  output logic             active,
  output logic [CNT_W-1:0] run_bytes,
  output pkt_stat_t        done_stat
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(MAX_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             active_q, oversize;
  err_code_t        code_n;

  always_comb begin
    cnt_inc   = (byte_in && cnt_q != SAT) ? cnt_q + 1'b1 : cnt_q;
    oversize  = cnt_inc > LIMIT;
    code_n    = norm_code(eop_code);
    done_stat.bytes = oversize ? LIMIT : cnt_inc;
    done_stat.code  = (oversize && !code_n[CODE_W-1]) ? EC_OVERSIZE : code_n;
    run_bytes = (cnt_q > LIMIT) ? LIMIT : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (eop_take) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_inc;
      active_q <= active_q | byte_in;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/rxsq_stat_fifo.sv
module rxsq_stat_fifo
  import rxsq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  pkt_stat_t push_stat,
  input  logic      pop,
  output pkt_stat_t head_stat,
  output logic      has_head,
  output logic      full,
  output logic      head_new
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          push_ok, pop_ok, head_new_q;
  pkt_stat_t     mem [DEPTH];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt_q != '0);
  assign cnt_nx  = cnt_q + CW'(push_ok) - CW'(pop_ok);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && !flush && wr_ptr == AW'(g)) mem[g] <= push_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      cnt_q      <= '0;
      head_new_q <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      cnt_q      <= cnt_nx;
      head_new_q <= (cnt_nx != '0) && ((cnt_q == '0) || pop_ok);
    end
  end

  assign head_stat = mem[rd_ptr];
  assign has_head  = (cnt_q != '0);
  assign head_new  = head_new_q;
endmodule

// File: rtl/rxsq_read_guard.sv
module rxsq_read_guard
  import rxsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             host_rd,
  input  logic             pop,
  input  logic [CNT_W-1:0] limit,
  output logic             underrun
);
  logic [CNT_W-1:0] off_q;
  logic             under_q, past_end;

  assign past_end = (off_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      off_q   <= '0;
      under_q <= 1'b0;
    end else begin
      if (host_rd && past_end) under_q <= 1'b1;
      if (pop)                       off_q <= '0;
      else if (host_rd && !past_end) off_q <= off_q + 1'b1;
    end
  end

  assign underrun = under_q;
endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
  import rxsq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int MAX_BYTES = 1514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_in,
  input  logic        eop_valid,
  output logic        eop_ready,
  input  logic [3:0]  eop_code,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  input  logic        host_rd,
  output logic [15:0] status_word,
  output logic        rx_complete,
  output logic        receiving,
  output logic        status_overrun,
  output logic        rx_underrun,
  output logic        adapter_fail
);
  logic             flush, discard, eop_take, full, has_head, underrun;
  logic [CNT_W-1:0] run_bytes, rd_limit;
  pkt_stat_t        done_stat, head_stat;

  assign flush     = cmd_valid && (cmd_op == OP_RX_RESET);
  assign discard   = cmd_valid && (cmd_op == OP_DISCARD);
  assign eop_ready = !full;
  assign eop_take  = eop_valid && eop_ready;

  rxsq_pkt_tracker #(.MAX_BYTES(MAX_BYTES)) i_track (
    .clk, .rst_n, .flush, .byte_in, .eop_take,
    .eop_code(err_code_t'(eop_code)),
    .active(receiving), .run_bytes, .done_stat
  );

  rxsq_stat_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk, .rst_n, .flush, .push(eop_take), .push_stat(done_stat),
    .pop(discard), .head_stat, .has_head, .full, .head_new(rx_complete)
  );

  assign rd_limit = has_head ? head_stat.bytes : run_bytes;

  rxsq_read_guard i_guard (
    .clk, .rst_n, .flush, .host_rd, .pop(discard && has_head),
    .limit(rd_limit), .underrun
  );

  assign status_word    = has_head ? {1'b0, head_stat}
                                   : {1'b1, EC_NONE, run_bytes};
  assign status_overrun = full;
  assign rx_underrun    = underrun;
  assign adapter_fail   = underrun;
endmodule

// File: rtl/rxsq_checker.sv
module rxsq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_in,
  input logic        cmd_valid,
  input logic [4:0]  cmd_op,
  input logic        host_rd,
  input logic [15:0] status_word,
  input logic        rx_complete,
  input logic        receiving,
  input logic        status_overrun,
  input logic        rx_underrun
);
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    status_overrun && !(cmd_valid && (cmd_op == 5'd8 || cmd_op == 5'd5))
    |=> status_overrun);

  a_r5_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun && !(cmd_valid && cmd_op == 5'd5) |=> rx_underrun);

  a_r5_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_underrun) |-> $past(host_rd));

  a_r7_receiving_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(receiving) |-> $past(byte_in));

  a_r9_complete_head: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |-> !status_word[15]);

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 5'd5
    |=> !rx_underrun && !status_overrun && !receiving && status_word == 16'h8000);
endmodule

bind rx_status_queue rxsq_checker i_rxsq_checker (
  .clk, .rst_n, .byte_in, .cmd_valid, .cmd_op, .host_rd, .status_word,
  .rx_complete, .receiving, .status_overrun, .rx_underrun
);

// File: tb/test_rx_status_queue.sv
`timescale 1ns/1ps
module test_rx_status_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_in = 1'b0, eop_valid = 1'b0, cmd_valid = 1'b0, host_rd = 1'b0;
  logic [3:0]  eop_code = 4'd0;
  logic [4:0]  cmd_op = 5'd0;
  logic        eop_ready, rx_complete, receiving, status_overrun, rx_underrun, adapter_fail;
  logic [15:0] status_word;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] exp_q [0:15];
  int exp_n = 0;

  always #4 clk = ~clk;

  rx_status_queue i_rx_status_queue (
    .clk, .rst_n, .byte_in, .eop_valid, .eop_ready, .eop_code, .cmd_valid,
    .cmd_op, .host_rd, .status_word, .rx_complete, .receiving,
    .status_overrun, .rx_underrun, .adapter_fail
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] norm(input logic [3:0] c);
    if (c == 4'd8 || c == 4'd9 || c == 4'd11 || c == 4'd12 || c == 4'd13 || c == 4'd2)
      return c;
    return 4'd0;
  endfunction

  function automatic logic [15:0] exp_word(input int len, input logic [3:0] c);
    logic [3:0] cc = norm(c);
    int l = len;
    if (len > 1514) begin
      l = 1514;
      if (!cc[3]) cc = 4'd9;
    end
    return {1'b0, cc, 11'(l)};
  endfunction

  function automatic logic [15:0] head_exp();
    return (exp_n == 0) ? 16'h8000 : exp_q[0];
  endfunction

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_in = 1'b1;
    end
    @(negedge clk); byte_in = 1'b0;
  endtask

  task automatic send_pkt(input int len, input logic [3:0] c);
    bit was_empty = (exp_n == 0);
    send_bytes(len);
    eop_valid = 1'b1; eop_code = c;
    while (!eop_ready) @(negedge clk);
    @(negedge clk); eop_valid = 1'b0;
    exp_q[exp_n] = exp_word(len, c); exp_n++;
    chk("R9 complete pulse on new head", 32'(rx_complete), 32'(was_empty));
    @(negedge clk);
    chk("R9 pulse lasts one cycle", 32'(rx_complete), 32'd0);
  endtask

  task automatic do_cmd(input logic [4:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic discard();
    bit more = (exp_n >= 2);
    do_cmd(5'd8);
    if (exp_n > 0) begin
      for (int i = 0; i < 15; i++) exp_q[i] = exp_q[i+1];
      exp_n--;
    end
    chk("R9 pulse after discard", 32'(rx_complete), 32'(more));
    chk("R6 head after discard", 32'(status_word), 32'(head_exp()));
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_rd = 1'b1;
    end
    @(negedge clk); host_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", 32'(status_word), 32'h8000);
    chk("R4 reset ready", 32'(eop_ready), 32'd1);
    chk("R5 reset underrun", 32'({rx_underrun, adapter_fail, status_overrun, receiving}), 32'd0);

    // R2 R3: every code with a small length, then discard.
    for (int c = 0; c < 16; c++) begin
      send_pkt(3 * c + 1, 4'(c));
      chk("R2 R3 status word", 32'(status_word), 32'(exp_word(3 * c + 1, 4'(c))));
      discard();
      chk("R1 empty after discard", 32'(status_word), 32'h8000);
    end
    discard();  // R6 discard on empty
    chk("R6 empty discard no effect", 32'(status_word), 32'h8000);

    // R7 R8 running count
    send_bytes(5);
    chk("R8 running count", 32'(status_word), 32'h8005);
    chk("R7 receiving", 32'(receiving), 32'd1);
    @(negedge clk); eop_valid = 1'b1; eop_code = 4'd13;
    @(negedge clk); eop_valid = 1'b0;
    chk("R7 receiving ends", 32'(receiving), 32'd0);
    chk("R2 crc code", 32'(status_word), 32'(exp_word(5, 4'd13)));
    exp_q[0] = exp_word(5, 4'd13); exp_n = 1;
    discard();

    // R3 length boundaries
    send_pkt(1514, 4'd0);
    chk("R3 exact limit", 32'(status_word), 32'(16'd1514));
    discard();
    send_pkt(1515, 4'd2);
    chk("R3 oversize over dribble", 32'(status_word), 32'({1'b0, 4'd9, 11'd1514}));
    discard();
    send_pkt(1516, 4'd13);
    chk("R3 crc kept when long", 32'(status_word), 32'({1'b0, 4'd13, 11'd1514}));
    discard();

    // R4 fill, stall, discard, drain
    for (int i = 0; i < 8; i++) send_pkt(10 + i, 4'(i));
    chk("R4 overrun when full", 32'(status_overrun), 32'd1);
    chk("R4 ready low when full", 32'(eop_ready), 32'd0);
    send_bytes(20);
    eop_valid = 1'b1; eop_code = 4'd11;
    repeat (3) @(negedge clk);
    chk("R4 stalled report not taken", 32'(status_word), 32'(head_exp()));
    cmd_valid = 1'b1; cmd_op = 5'd8;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R4 overrun clears", 32'(status_overrun), 32'd0);
    for (int i = 0; i < 15; i++) exp_q[i] = exp_q[i+1];
    exp_n--;
    @(negedge clk); eop_valid = 1'b0;
    exp_q[exp_n] = exp_word(20, 4'd11); exp_n++;
    chk("R4 full again", 32'(status_overrun), 32'd1);
    for (int i = 0; i < 8; i++) begin
      chk("R6 FIFO order", 32'(status_word), 32'(head_exp()));
      discard();
    end
    chk("R1 drained", 32'(status_word), 32'h8000);

    // R5 underrun
    send_pkt(4, 4'd0);
    reads(4);
    chk("R5 no underrun at end", 32'(rx_underrun), 32'd0);
    reads(1);
    chk("R5 underrun past end", 32'(rx_underrun), 32'd1);
    chk("R5 adapter fail", 32'(adapter_fail), 32'd1);
    discard();
    chk("R5 sticky over discard", 32'(rx_underrun), 32'd1);
    do_cmd(5'd5);
    chk("R10 underrun cleared", 32'(rx_underrun), 32'd0);
    reads(1);
    chk("R5 read on empty", 32'(rx_underrun), 32'd1);
    do_cmd(5'd5);

    // R11 ignored opcodes
    send_pkt(7, 4'd12);
    do_cmd(5'd3);
    do_cmd(5'd31);
    chk("R11 ignored opcodes", 32'(status_word), 32'(head_exp()));
    chk("R11 flags untouched", 32'({rx_underrun, status_overrun}), 32'd0);

    // R10 receive reset
    send_pkt(2, 4'd8);
    send_pkt(3, 4'd1);
    send_bytes(6);
    do_cmd(5'd5);
    exp_n = 0;
    chk("R10 queue emptied", 32'(status_word), 32'h8000);
    chk("R10 receiving cleared", 32'(receiving), 32'd0);
    send_pkt(2, 4'd0);
    chk("R10 in-progress count dropped", 32'(status_word), 32'h0002);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule